// File: doc/BRIEF.md
# Two-Operand NaN Propagation Selector

This block sits beside the datapath of a two-input floating-point operation and chooses the result once at least one operand has been classed as a NaN. It takes both operand encodings, a class code for each operand, a propagation-policy select and a default-NaN enable. It returns a result NaN that is always quiet, together with an invalid flag. Both outputs are combinational and settle in the same cycle as the inputs.

Four policies are available. Two of them rank signalling NaNs first and then quiet NaNs, one starting from operand A and the other from operand B. One returns operand A whenever A is a NaN of either kind. The magnitude policy compares the fraction fields and uses the sign as a tie-break. When default-NaN mode is set, the operands are never passed through and a fixed quiet NaN pattern is returned in their place. The invalid flag is still raised as usual in that mode.

Operands use a sign / exponent / fraction layout set by `EXP_W` and `FRAC_W`. The defaults give a 32-bit word with the fraction in bits 22:0, and bit 22 is the quiet bit. Class codes are 2'b00 for a non-NaN number, 2'b01 for a quiet NaN and 2'b10 for a signalling NaN. Code 2'b11 is handled as a non-NaN. Policy codes on `mode` are 0 for signalling-first starting at A, 1 for first-operand, 2 for signalling-first starting at B and 3 for magnitude.

Top module: `nan_pick_sel`

## Requirements
- R1: `invalid` is 1 exactly when `clsA` or `clsB` is 2'b10 (signalling). This holds in every mode and whether or not default-NaN mode is set.
- R2: With `defaultMode` = 1, `result` is the default NaN: sign 0, exponent all ones, fraction MSB 1, all other fraction bits 0 (32'h7FC00000 at the defaults). The operands and the mode do not change this.
- R3: Mode 0 returns A if A is signalling, else B if B is signalling, else A if A is quiet, else B.
- R4: Mode 1 returns A when A is any NaN and B otherwise.
- R5: Mode 2 returns B if B is signalling, else A if A is signalling, else B if B is quiet, else A.
- R6: In mode 3, a signalling NaN paired with a quiet NaN returns the quiet one. A NaN paired with a non-NaN returns the NaN.
- R7: In mode 3, when both operands are NaNs of the same kind, the operand whose fraction field (bits FRAC_W-1:0) is larger as an unsigned number is returned.
- R8: In mode 3, when both operands are NaNs of the same kind with equal fractions, the operand whose sign bit is 0 is returned.
- R9: A selected signalling NaN is output with the fraction MSB (bit 22 at the defaults) forced to 1 and every other bit unchanged. A selected quiet NaN is output unchanged.
- R10: When neither operand is classed as a NaN, `result` is the default NaN and `invalid` is 0.
- R11: `result` and `invalid` depend only on the present inputs, with no register on the path. They are valid in the same cycle the inputs are applied.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clsA | input | 2 | Class code of operand A |
| clsB | input | 2 | Class code of operand B |
| opA | input | 1+EXP_W+FRAC_W | Encoding of operand A |
| opB | input | 1+EXP_W+FRAC_W | Encoding of operand B |
| mode | input | 2 | Propagation policy select |
| defaultMode | input | 1 | Return the default NaN instead of an operand |
| result | output | 1+EXP_W+FRAC_W | Chosen quiet NaN |
| invalid | output | 1 | A signalling NaN was present |

## Verification
The invalid flag and the default-NaN substitution can both act on the same vector. In that case the operand that caused the flag never reaches the output. The bench provokes this by applying a signalling NaN with `defaultMode` set. It then checks in that one sample that `invalid` is 1 and that `result` is exactly the default pattern rather than the quieted operand. A second vector uses two quiet NaNs with default mode set and checks that the substitution happens with the flag left low.

// File: rtl/nan_pick_pkg.sv
package nan_pick_pkg;

  // Operand class codes supplied by the upstream classifier.
  typedef enum logic [1:0] {
    CLS_NUM  = 2'b00,
    CLS_QNAN = 2'b01,
    CLS_SNAN = 2'b10,
    CLS_RSVD = 2'b11
  } cls_e;

  // Propagation policies.
  typedef enum logic [1:0] {
    MODE_SNAN_AB   = 2'd0,
    MODE_FIRST_ANY = 2'd1,
    MODE_SNAN_BA   = 2'd2,
    MODE_MAGNITUDE = 2'd3
  } mode_e;

  // Strobes from the policy control to the datapath.
  typedef struct packed {
    logic pickB;      // take operand B instead of A
    logic useDefault; // replace the selection by the default NaN
    logic quietOut;   // the selection is signalling and must be quieted
    logic invalid;    // a signalling NaN was seen
  } ctl_t;

endpackage

// File: rtl/nan_pick_ctrl.sv
module nan_pick_ctrl
  import nan_pick_pkg::*;
(
  input  cls_e  clsA,
  input  cls_e  clsB,
  input  mode_e mode,
  input  logic  defaultMode,
  input  logic  aLarger,
  output ctl_t  ctl
);

  logic aSnan, bSnan, aQnan, bQnan, aNan, bNan;
  logic pickB;

  always_comb begin
    aSnan = (clsA == CLS_SNAN);
    bSnan = (clsB == CLS_SNAN);
    aQnan = (clsA == CLS_QNAN);
    bQnan = (clsB == CLS_QNAN);
    aNan  = aSnan || aQnan;
    bNan  = bSnan || bQnan;
  end

  always_comb begin
    pickB = 1'b0;
    case (mode)
      MODE_SNAN_AB: begin
        if (aSnan)      pickB = 1'b0;
        else if (bSnan) pickB = 1'b1;
        else if (aQnan) pickB = 1'b0;
        else            pickB = 1'b1;
      end
      MODE_FIRST_ANY: begin
        pickB = !aNan;
      end
      MODE_SNAN_BA: begin
        if (bSnan)      pickB = 1'b1;
        else if (aSnan) pickB = 1'b0;
        else if (bQnan) pickB = 1'b1;
        else            pickB = 1'b0;
      end
      MODE_MAGNITUDE: begin
        if ((aSnan && bSnan) || (aQnan && bQnan)) pickB = !aLarger;
        else if (aSnan && bQnan)                  pickB = 1'b1;
        else if (aQnan && bSnan)                  pickB = 1'b0;
        else                                      pickB = !aNan;
      end
      default: pickB = 1'b0;
    endcase
  end

  always_comb begin
    ctl.pickB      = pickB;
    ctl.useDefault = defaultMode || !(aNan || bNan);
    ctl.quietOut   = pickB ? bSnan : aSnan;
    ctl.invalid    = aSnan || bSnan;
  end

endmodule

// File: rtl/nan_pick_dp.sv
module nan_pick_dp
  import nan_pick_pkg::*;
#(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23
) (
  input  logic [EXP_W+FRAC_W:0] opA,
  input  logic [EXP_W+FRAC_W:0] opB,
  input  ctl_t                  ctl,
  output logic                  aLarger,
  output logic [EXP_W+FRAC_W:0] result
);

  localparam int W = 1 + EXP_W + FRAC_W;
  localparam logic [W-1:0] QUIET_BIT = W'(1) << (FRAC_W - 1);
  localparam logic [W-1:0] DEF_NAN   = {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};

  logic [FRAC_W-1:0] fracA, fracB;
  logic              signA, signB;
  logic [W-1:0]      chosen, quieted;

  // Significand comparison with sign tie-break for the magnitude policy.
  always_comb begin
    fracA = opA[FRAC_W-1:0];
    fracB = opB[FRAC_W-1:0];
    signA = opA[W-1];
    signB = opB[W-1];
    if (fracA > fracB)      aLarger = 1'b1;
    else if (fracA < fracB) aLarger = 1'b0;
    else                    aLarger = !signA && signB;
  end

  always_comb begin
    chosen  = ctl.pickB ? opB : opA;
    quieted = ctl.quietOut ? (chosen | QUIET_BIT) : chosen;
    result  = ctl.useDefault ? DEF_NAN : quieted;
  end

endmodule

// File: rtl/nan_pick_sel.sv
module nan_pick_sel
  import nan_pick_pkg::*;
#(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23
) (
  input  logic [1:0]             clsA,
  input  logic [1:0]             clsB,
  input  logic [EXP_W+FRAC_W:0]  opA,
  input  logic [EXP_W+FRAC_W:0]  opB,
  input  logic [1:0]             mode,
  input  logic                   defaultMode,
  output logic [EXP_W+FRAC_W:0]  result,
  output logic                   invalid
);

  ctl_t ctl;
  logic aLarger;

  nan_pick_ctrl u_ctrl (
    .clsA        (cls_e'(clsA)),
    .clsB        (cls_e'(clsB)),
    .mode        (mode_e'(mode)),
    .defaultMode (defaultMode),
    .aLarger     (aLarger),
    .ctl         (ctl)
  );

  nan_pick_dp #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_dp (
    .opA     (opA),
    .opB     (opB),
    .ctl     (ctl),
    .aLarger (aLarger),
    .result  (result)
  );

  assign invalid = ctl.invalid;

endmodule

// File: rtl/nan_pick_chk.sv
module nan_pick_chk #(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23
) (
  input logic [1:0]            clsA,
  input logic [1:0]            clsB,
  input logic [EXP_W+FRAC_W:0] opA,
  input logic [EXP_W+FRAC_W:0] opB,
  input logic [1:0]            mode,
  input logic                  defaultMode,
  input logic [EXP_W+FRAC_W:0] result,
  input logic                  invalid
);

  localparam int W = 1 + EXP_W + FRAC_W;
  localparam logic [W-1:0] QB  = W'(1) << (FRAC_W - 1);
  localparam logic [W-1:0] DEF = {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};

  logic known, anyNan, sigA, sigB;

  always_comb begin
    known  = !$isunknown({clsA, clsB, opA, opB, mode, defaultMode, result, invalid});
    sigA   = (clsA == 2'b10);
    sigB   = (clsB == 2'b10);
    anyNan = sigA || sigB || (clsA == 2'b01) || (clsB == 2'b01);
    if (known) begin
      // R1: flag tracks signalling operands only
      a_r1_invalid_flag: assert (invalid == (sigA || sigB))
        else $error("a_r1_invalid_flag");
      // R2: default mode hides the operands
      a_r2_default_nan: assert (!defaultMode || result == DEF)
        else $error("a_r2_default_nan");
      // R10: nothing to propagate gives the default NaN without a flag
      a_r10_no_nan: assert (anyNan || (result == DEF && !invalid))
        else $error("a_r10_no_nan");
      // R9: output is one of the operands up to the quiet bit
      a_r9_from_operand: assert (defaultMode || !anyNan ||
                                 (result | QB) == (opA | QB) || (result | QB) == (opB | QB))
        else $error("a_r9_from_operand");
      // R4: first-operand policy keeps A when A is a NaN
      a_r4_first_any: assert (defaultMode || mode != 2'd1 ||
                              !(sigA || clsA == 2'b01) || (result | QB) == (opA | QB))
        else $error("a_r4_first_any");
    end
  end

endmodule

bind nan_pick_sel nan_pick_chk #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_chk (
  .clsA(clsA), .clsB(clsB), .opA(opA), .opB(opB), .mode(mode),
  .defaultMode(defaultMode), .result(result), .invalid(invalid)
);

// File: tb/nan_pick_sel_tb.sv
module nan_pick_sel_tb;

  typedef struct {
    logic [31:0] res;
    logic        inv;
    string       tag;
  } exp_t;

  localparam logic [1:0] NUM = 2'b00, QN = 2'b01, SN = 2'b10;
  localparam logic [31:0] DEF = 32'h7FC0_0000;
  localparam logic [31:0] QA  = 32'h7FC0_1234, QBV = 32'hFFC0_0055;
  localparam logic [31:0] SA  = 32'h7F80_0001, SAQ = 32'h7FC0_0001;
  localparam logic [31:0] SB  = 32'hFF80_0100, SBQ = 32'hFFC0_0100;
  localparam logic [31:0] N1  = 32'h3F80_0000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [1:0]  clsA, clsB, mode;
  logic [31:0] opA, opB, result;
  logic        defaultMode, invalid;

  exp_t q[$];
  int   vectors = 0;
  int   miscompares = 0;
  bit   done = 1'b0;

  always #5 clk = ~clk;

  nan_pick_sel u_dut (
    .clsA(clsA), .clsB(clsB), .opA(opA), .opB(opB), .mode(mode),
    .defaultMode(defaultMode), .result(result), .invalid(invalid)
  );

  task automatic drive(input logic [1:0] ca, input logic [1:0] cb,
                       input logic [31:0] a, input logic [31:0] b,
                       input logic [1:0] m, input logic d,
                       input logic [31:0] er, input logic ei, input string tag);
    exp_t e;
    @(posedge clk);
    #1;
    clsA = ca; clsB = cb; opA = a; opB = b; mode = m; defaultMode = d;
    e.res = er; e.inv = ei; e.tag = tag;
    q.push_back(e);
  endtask

  // Monitor: one expected item per cycle, sampled at the falling edge (R11: same cycle).
  initial begin
    forever begin
      @(negedge clk);
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        vectors++;
        if (result !== e.res || invalid !== e.inv) begin
          miscompares++;
          $display("FAIL %s: result=%h invalid=%b expected result=%h invalid=%b",
                   e.tag, result, invalid, e.res, e.inv);
        end
      end
    end
  end

  initial begin
    clsA = NUM; clsB = NUM; opA = '0; opB = '0; mode = 2'd0; defaultMode = 1'b0;
    repeat (3) @(posedge clk);
    rst = 1'b0;
    // Reset state: idle inputs hold no NaN
    drive(NUM, NUM, 32'h0, 32'h0, 2'd0, 1'b0, DEF, 1'b0, "R10 reset idle");
    drive(NUM, NUM, N1, N1, 2'd3, 1'b0, DEF, 1'b0, "R10 numbers mode3");
    // Mode 0
    drive(QN, SN, QA, SB, 2'd0, 1'b0, SBQ, 1'b1, "R3 qA sB");
    drive(SN, SN, SA, SB, 2'd0, 1'b0, SAQ, 1'b1, "R3 sA sB");
    drive(NUM, QN, N1, QBV, 2'd0, 1'b0, QBV, 1'b0, "R3 num qB");
    drive(QN, QN, QA, QBV, 2'd0, 1'b0, QA, 1'b0, "R3 qA qB");
    // Mode 1
    drive(QN, SN, QA, SB, 2'd1, 1'b0, QA, 1'b1, "R4 qA sB");
    drive(NUM, SN, N1, SB, 2'd1, 1'b0, SBQ, 1'b1, "R4 num sB");
    // Mode 2
    drive(SN, SN, SA, SB, 2'd2, 1'b0, SBQ, 1'b1, "R5 sA sB");
    drive(QN, QN, QA, QBV, 2'd2, 1'b0, QBV, 1'b0, "R5 qA qB");
    drive(SN, QN, SA, QBV, 2'd2, 1'b0, SAQ, 1'b1, "R5 sA qB");
    drive(QN, NUM, QA, N1, 2'd2, 1'b0, QA, 1'b0, "R5 qA num");
    // Mode 3 mixed kinds
    drive(SN, QN, SA, QBV, 2'd3, 1'b0, QBV, 1'b1, "R6 sA qB");
    drive(QN, SN, QA, SB, 2'd3, 1'b0, QA, 1'b1, "R6 qA sB");
    drive(NUM, SN, N1, SB, 2'd3, 1'b0, SBQ, 1'b1, "R6 num sB");
    drive(QN, NUM, QA, N1, 2'd3, 1'b0, QA, 1'b0, "R6 qA num");
    // Mode 3 same kind, larger fraction
    drive(QN, QN, QA, QBV, 2'd3, 1'b0, QA, 1'b0, "R7 two quiet");
    drive(SN, SN, SA, SB, 2'd3, 1'b0, SBQ, 1'b1, "R7 two signalling");
    // Mode 3 equal fractions, positive sign wins
    drive(QN, QN, 32'hFFC0_0077, 32'h7FC0_0077, 2'd3, 1'b0, 32'h7FC0_0077, 1'b0, "R8 neg A pos B");
    drive(QN, QN, 32'h7FC0_0077, 32'hFFC0_0077, 2'd3, 1'b0, 32'h7FC0_0077, 1'b0, "R8 pos A neg B");
    drive(SN, SN, 32'hFF80_0009, 32'h7F80_0009, 2'd3, 1'b0, 32'h7FC0_0009, 1'b1, "R8 two signalling tie");
    // Quieting keeps other bits
    drive(SN, NUM, 32'hFFBF_FFFF, N1, 2'd0, 1'b0, 32'hFFFF_FFFF, 1'b1, "R9 quiet bit only");
    drive(QN, NUM, QBV, N1, 2'd1, 1'b0, QBV, 1'b0, "R9 quiet unchanged");
    // Default mode, alone and together with the invalid flag
    drive(SN, QN, SA, QBV, 2'd3, 1'b1, DEF, 1'b1, "R2 R1 default with signalling");
    drive(QN, QN, QA, QBV, 2'd1, 1'b1, DEF, 1'b0, "R2 default quiet");
    drive(NUM, SN, N1, SB, 2'd2, 1'b1, DEF, 1'b1, "R1 flag in default mode");
    repeat (3) @(posedge clk);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: expected=finish actual=timeout");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

endmodule